// File: doc/BRIEF.md
# Receiver Reset Sequencer

This block drives the analog and digital reset inputs of a multi-lane serial receiver. Its job is to move every lane's clock-data-recovery loop from tracking the reference clock to tracking incoming data without leaving a lane stuck. A start request, or any later restart request, puts the receiver into full reset. The block then waits for every lane's frequency-lock bit to drop. It releases the analog reset only once input data is confirmed present, waits for every lane to report lock again, and lets a fixed settle time pass before it releases the digital reset and raises ready.

Data presence is judged by an external qualifier. When the signal-detect input is enabled, that input must also stay high together with the qualifier for a long run of consecutive parallel-clock cycles. The settle time is given in nanoseconds and turned into clock cycles from a clock-frequency parameter, rounded up. A timeout bounds each wait on the lock bits. Losing lock, or losing signal detect, during the settle time or after ready throws the sequence back into full reset. The lock vector and signal detect pass through two-stage synchronisers before use.

Top module: `rxrst_seq`

## Requirements
- R1: After the active-low reset `rstN`, `analogRst` and `digitalRst` are high and `ready` is low. These values hold, whatever the other inputs do, until `startReq` is seen high at a clock edge.
- R2: `startReq` high at a clock edge, in any state, makes `analogRst` and `digitalRst` high and `ready` low in the following cycle, and the sequence starts again from the lock-fall wait.
- R3: `analogRst` stays high while any bit of the synchronised `lockVec` is still high. The lock-fall wait ends at the first edge where all synchronised lock bits are low.
- R4: With `USE_SIGDET`=1, `analogRst` falls only after `dataOk` and synchronised `sigDet` have both been high at `DET_CYCLES` consecutive clock edges. A single low cycle of either input restarts the count.
- R5: With `USE_SIGDET`=0, `analogRst` falls at the first edge in the data wait where `dataOk` is high. `sigDet` has no effect anywhere in the sequence, including after ready.
- R6: After `analogRst` falls, `digitalRst` stays high until all synchronised lock bits are high. It then falls exactly `SETTLE_CYC` = ceil(`SETTLE_NS`*`CLK_MHZ`/1000) cycles later. A lane lock rising at the inputs reaches the state logic after two register stages.
- R7: If any synchronised lock bit is low, or (with `USE_SIGDET`=1) synchronised `sigDet` is low, during the settle time or while ready, both resets are high and `ready` is low in the next cycle.
- R8: If the lock bits have not all fallen, or not all risen, within `TIMEOUT_CYC` cycles of their wait starting, the sequence restarts from the lock-fall wait. In the rise wait this is seen as `analogRst` going high again.
- R9: `ready` is high only while both `analogRst` and `digitalRst` are low, and `digitalRst` is never low while `analogRst` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | Start or restart the reset sequence |
| lockVec | input | LANES | Per-lane frequency-lock indication (asynchronous) |
| sigDet | input | 1 | Link signal detect (asynchronous) |
| dataOk | input | 1 | External qualifier that data is present at the receiver inputs |
| analogRst | output | 1 | Analog reset to the receiver lanes |
| digitalRst | output | 1 | Digital reset to the receiver lanes |
| ready | output | 1 | Sequence complete, receiver usable |

## Verification
The bench builds two instances side by side: one with signal detect enabled and `DET_CYCLES`=16, one with signal detect disabled. Both use `TIMEOUT_CYC`=40, `CLK_MHZ`=100 and `SETTLE_NS`=95. That last pair makes a 10-cycle settle time through the round-up. These short windows put the data-presence run with a mid-run dropout, both wait timeouts, the exact settle count, and fault returns from settle and ready within a few hundred cycles. Running the two instances side by side shows that signal detect is ignored when disabled, while the enabled instance drops out on the same stimulus.

// File: rtl/rxrst_pkg.sv
package rxrst_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_LTR    = 3'd1,
    ST_DATA   = 3'd2,
    ST_LTD    = 3'd3,
    ST_SETTLE = 3'd4,
    ST_READY  = 3'd5
  } seqState_t;

  // control -> datapath
  typedef struct packed {
    logic cntClr;
    logic cntInc;
  } dpStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic allLow;
    logic allHigh;
    logic qualOk;
    logic linkFault;
    logic detDone;
    logic settleDone;
    logic waitExpired;
  } dpFlags_t;

  function automatic int ceilDiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int maxOf3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/rxrst_dp.sv
module rxrst_dp
  import rxrst_pkg::*;
#(
  parameter int LANES       = 4,
  parameter int DET_CYCLES  = 65536,
  parameter int SETTLE_CYC  = 500,
  parameter int TIMEOUT_CYC = 262144,
  parameter bit USE_SIGDET  = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LANES-1:0] lockVec,
  input  logic             sigDet,
  input  logic             dataOk,
  input  dpStrobe_t        strobe,
  output dpFlags_t         flags
);

  localparam int DET_LIMIT = USE_SIGDET ? DET_CYCLES : 1;
  localparam int CNT_MAX   = maxOf3(DET_LIMIT, SETTLE_CYC, TIMEOUT_CYC);
  localparam int CNT_W     = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] DET_LAST     = CNT_W'(DET_LIMIT - 1);
  localparam logic [CNT_W-1:0] SETTLE_LAST  = CNT_W'(SETTLE_CYC - 1);
  localparam logic [CNT_W-1:0] TIMEOUT_LAST = CNT_W'(TIMEOUT_CYC - 1);

  logic [LANES-1:0] lockMeta, lockSync;
  logic             sigMeta, sigSync;
  logic [CNT_W-1:0] cnt;
  logic             sigOk;

  // two-stage synchronisers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockMeta <= '0;
      lockSync <= '0;
      sigMeta  <= 1'b0;
      sigSync  <= 1'b0;
    end else begin
      lockMeta <= lockVec;
      lockSync <= lockMeta;
      sigMeta  <= sigDet;
      sigSync  <= sigMeta;
    end
  end

  // shared interval counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              cnt <= '0;
    else if (strobe.cntClr) cnt <= '0;
    else if (strobe.cntInc) cnt <= cnt + 1'b1;
  end

  generate
    if (USE_SIGDET) begin : g_sigdet
      assign sigOk = sigSync;
    end else begin : g_nosigdet
      logic unusedSig;
      assign unusedSig = sigSync;
      assign sigOk     = 1'b1;
    end
  endgenerate

  always_comb begin
    flags.allLow      = (lockSync == '0);
    flags.allHigh     = &lockSync;
    flags.qualOk      = dataOk && sigOk;
    flags.linkFault   = !(&lockSync) || !sigOk;
    flags.detDone     = (cnt == DET_LAST);
    flags.settleDone  = (cnt == SETTLE_LAST);
    flags.waitExpired = (cnt == TIMEOUT_LAST);
  end

endmodule

// File: rtl/rxrst_ctrl.sv
module rxrst_ctrl
  import rxrst_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      startReq,
  input  dpFlags_t  flags,
  output dpStrobe_t strobe,
  output logic      analogRst,
  output logic      digitalRst,
  output logic      ready
);

  seqState_t state, stateNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    stateNxt      = state;
    strobe.cntClr = 1'b0;
    strobe.cntInc = 1'b0;
    if (startReq) begin
      stateNxt      = ST_LTR;
      strobe.cntClr = 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: ;
        ST_LTR: begin
          if (flags.allLow) begin
            stateNxt      = ST_DATA;
            strobe.cntClr = 1'b1;
          end else if (flags.waitExpired) begin
            stateNxt      = ST_LTR;
            strobe.cntClr = 1'b1;
          end else begin
            strobe.cntInc = 1'b1;
          end
        end
        ST_DATA: begin
          if (!flags.qualOk) begin
            strobe.cntClr = 1'b1;
          end else if (flags.detDone) begin
            stateNxt      = ST_LTD;
            strobe.cntClr = 1'b1;
          end else begin
            strobe.cntInc = 1'b1;
          end
        end
        ST_LTD: begin
          if (flags.allHigh) begin
            stateNxt      = ST_SETTLE;
            strobe.cntClr = 1'b1;
          end else if (flags.waitExpired) begin
            stateNxt      = ST_LTR;
            strobe.cntClr = 1'b1;
          end else begin
            strobe.cntInc = 1'b1;
          end
        end
        ST_SETTLE: begin
          if (flags.linkFault) begin
            stateNxt      = ST_LTR;
            strobe.cntClr = 1'b1;
          end else if (flags.settleDone) begin
            stateNxt      = ST_READY;
            strobe.cntClr = 1'b1;
          end else begin
            strobe.cntInc = 1'b1;
          end
        end
        ST_READY: begin
          if (flags.linkFault) begin
            stateNxt      = ST_LTR;
            strobe.cntClr = 1'b1;
          end
        end
        default: begin
          stateNxt      = ST_IDLE;
          strobe.cntClr = 1'b1;
        end
      endcase
    end
  end

  always_comb begin
    analogRst  = (state == ST_IDLE) || (state == ST_LTR) || (state == ST_DATA);
    digitalRst = (state != ST_READY);
    ready      = (state == ST_READY);
  end

endmodule

// File: rtl/rxrst_seq.sv
module rxrst_seq
  import rxrst_pkg::*;
#(
  parameter int LANES       = 4,
  parameter int DET_CYCLES  = 65536,
  parameter int CLK_MHZ     = 125,
  parameter int SETTLE_NS   = 4000,
  parameter int TIMEOUT_CYC = 262144,
  parameter bit USE_SIGDET  = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic [LANES-1:0] lockVec,
  input  logic             sigDet,
  input  logic             dataOk,
  output logic             analogRst,
  output logic             digitalRst,
  output logic             ready
);

  localparam int SETTLE_RAW = ceilDiv(SETTLE_NS * CLK_MHZ, 1000);
  localparam int SETTLE_CYC = (SETTLE_RAW < 1) ? 1 : SETTLE_RAW;

  dpStrobe_t strobe;
  dpFlags_t  flags;

  rxrst_dp #(
    .LANES(LANES), .DET_CYCLES(DET_CYCLES), .SETTLE_CYC(SETTLE_CYC),
    .TIMEOUT_CYC(TIMEOUT_CYC), .USE_SIGDET(USE_SIGDET)
  ) u_dp (
    .clk(clk), .rstN(rstN), .lockVec(lockVec), .sigDet(sigDet),
    .dataOk(dataOk), .strobe(strobe), .flags(flags)
  );

  rxrst_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .flags(flags),
    .strobe(strobe), .analogRst(analogRst), .digitalRst(digitalRst),
    .ready(ready)
  );

endmodule

// File: rtl/rxrst_chk.sv
module rxrst_chk #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             startReq,
  input logic [LANES-1:0] lockVec,
  input logic             dataOk,
  input logic             analogRst,
  input logic             digitalRst,
  input logic             ready
);

  AST_READY_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    ready |-> (!analogRst && !digitalRst)); // R9

  AST_RESET_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    !digitalRst |-> !analogRst); // R9

  AST_START_RESETS: assert property (@(posedge clk) disable iff (!rstN)
    startReq |=> (analogRst && digitalRst && !ready)); // R2

  AST_ANALOG_QUAL: assert property (@(posedge clk) disable iff (!rstN)
    $fell(analogRst) |-> $past(dataOk)); // R4

  AST_LOCK_AT_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(digitalRst) |-> $past(&lockVec, 3)); // R6

  AST_READY_LOSS: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ready) |-> (analogRst && digitalRst)); // R7

endmodule

bind rxrst_seq rxrst_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rstN(rstN), .startReq(startReq), .lockVec(lockVec),
  .dataOk(dataOk), .analogRst(analogRst), .digitalRst(digitalRst),
  .ready(ready)
);

// File: tb/tb_rxrst_seq.sv
module tb_rxrst_seq;

  localparam int LANES   = 4;
  localparam int DET     = 16;
  localparam int TO      = 40;
  localparam int CLKMHZ  = 100;
  localparam int SETNS   = 95;
  localparam int SETTLE  = (SETNS * CLKMHZ + 999) / 1000;  // 10

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0;
  logic [LANES-1:0] lockVec = '1;
  logic sigDet = 1'b0;
  logic dataOk = 1'b0;
  logic aR [2];
  logic dR [2];
  logic rdy [2];

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  rxrst_seq #(.LANES(LANES), .DET_CYCLES(DET), .CLK_MHZ(CLKMHZ),
    .SETTLE_NS(SETNS), .TIMEOUT_CYC(TO), .USE_SIGDET(1'b1)) dut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .lockVec(lockVec),
    .sigDet(sigDet), .dataOk(dataOk), .analogRst(aR[0]),
    .digitalRst(dR[0]), .ready(rdy[0]));

  rxrst_seq #(.LANES(LANES), .DET_CYCLES(DET), .CLK_MHZ(CLKMHZ),
    .SETTLE_NS(SETNS), .TIMEOUT_CYC(TO), .USE_SIGDET(1'b0)) dutNoDet (
    .clk(clk), .rstN(rstN), .startReq(startReq), .lockVec(lockVec),
    .sigDet(sigDet), .dataOk(dataOk), .analogRst(aR[1]),
    .digitalRst(dR[1]), .ready(rdy[1]));

  // behavioural reference: phase 0 idle,1 fall wait,2 data wait,3 rise wait,4 settle,5 ready
  int mPh [2];
  int mCnt [2];
  logic [LANES-1:0] mL1 [2];
  logic [LANES-1:0] mL2 [2];
  logic mG1 [2];
  logic mG2 [2];

  task automatic modelStep(input int i);
    bit useS;
    int lim, np, nc;
    bit lowAll, highAll, sigOk, qual;
    useS    = (i == 0);
    lim     = useS ? DET : 1;
    lowAll  = (mL2[i] == '0);
    highAll = (mL2[i] == '1);
    sigOk   = mG2[i] || !useS;
    qual    = dataOk && sigOk;
    np = mPh[i];
    nc = mCnt[i];
    if (startReq) begin np = 1; nc = 0; end
    else if (mPh[i] == 1) begin
      if (lowAll) begin np = 2; nc = 0; end
      else if (mCnt[i] == TO - 1) nc = 0;
      else nc = nc + 1;
    end else if (mPh[i] == 2) begin
      if (!qual) nc = 0;
      else if (mCnt[i] == lim - 1) begin np = 3; nc = 0; end
      else nc = nc + 1;
    end else if (mPh[i] == 3) begin
      if (highAll) begin np = 4; nc = 0; end
      else if (mCnt[i] == TO - 1) begin np = 1; nc = 0; end
      else nc = nc + 1;
    end else if (mPh[i] == 4) begin
      if (!highAll || !sigOk) begin np = 1; nc = 0; end
      else if (mCnt[i] == SETTLE - 1) begin np = 5; nc = 0; end
      else nc = nc + 1;
    end else if (mPh[i] == 5) begin
      if (!highAll || !sigOk) begin np = 1; nc = 0; end
    end
    mPh[i]  = np;
    mCnt[i] = nc;
    mL2[i]  = mL1[i];
    mL1[i]  = lockVec;
    mG2[i]  = mG1[i];
    mG1[i]  = sigDet;
  endtask

  always @(posedge clk) begin
    for (int i = 0; i < 2; i++) begin
      if (!rstN) begin
        mPh[i] = 0; mCnt[i] = 0; mL1[i] = '0; mL2[i] = '0;
        mG1[i] = 1'b0; mG2[i] = 1'b0;
      end else begin
        modelStep(i);
      end
    end
  end

  function automatic string phTag(input int p);
    case (p)
      0: return "R1";
      1: return "R3";
      2: return "R4";
      3: return "R8";
      4: return "R6";
      default: return "R9";
    endcase
  endfunction

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (rstN && !done) begin
      for (int i = 0; i < 2; i++) begin
        logic [2:0] act, exp;
        act = {aR[i], dR[i], rdy[i]};
        exp = {(mPh[i] <= 2), (mPh[i] != 5), (mPh[i] == 5)};
        checks++;
        if (act !== exp) begin
          fails++;
          $display("FAIL %s inst%0d model compare: actual %b expected %b",
                   phTag(mPh[i]), i, act, exp);
        end
      end
    end
  end

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic chk(input string req, input logic act, input logic exp,
                     input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    finishRun();
  end

  initial begin
    @(negedge clk);
    tick(3);
    rstN = 1'b1;
    // R1: idle ignores everything but start
    lockVec = '0; dataOk = 1'b1; sigDet = 1'b1;
    tick(6);
    chk("R1", aR[0], 1'b1, "analog held in idle");
    chk("R1", dR[0], 1'b1, "digital held in idle");
    chk("R1", rdy[0], 1'b0, "ready low in idle");
    chk("R1", aR[1], 1'b1, "nodet analog held in idle");

    // R3: locks stuck high keep analog reset asserted
    lockVec = '1;
    tick(3);
    startReq = 1'b1; tick(1); startReq = 1'b0;
    chk("R2", aR[0] & dR[0] & !rdy[0], 1'b1, "resets after start");
    tick(20);
    chk("R3", aR[0], 1'b1, "analog held while locks high");
    chk("R3", aR[1], 1'b1, "nodet analog held while locks high");

    // locks fall, data wait
    dataOk = 1'b0; lockVec = '0;
    tick(5);
    dataOk = 1'b1;
    tick(1);
    chk("R5", aR[1], 1'b0, "nodet analog released on first dataOk");
    chk("R4", aR[0], 1'b1, "analog still held at run start");
    tick(7);
    dataOk = 1'b0; tick(1); dataOk = 1'b1;
    tick(15);
    chk("R4", aR[0], 1'b1, "analog held after 15 of 16 after gap");
    tick(1);
    chk("R4", aR[0], 1'b0, "analog released after 16 consecutive");

    // R8: rise-wait timeout
    tick(39);
    chk("R8", aR[0], 1'b0, "analog low before timeout");
    tick(1);
    chk("R8", aR[0], 1'b1, "analog reasserted at timeout");

    // R2: restart, then full sequence
    startReq = 1'b1; tick(1); startReq = 1'b0;
    chk("R2", aR[1] & dR[1] & !rdy[1], 1'b1, "nodet resets after restart");
    tick(18);
    chk("R4", aR[0], 1'b0, "analog released after restart");
    lockVec = 4'b0001; tick(1);
    lockVec = 4'b0011; tick(1);
    lockVec = 4'b0111; tick(1);
    lockVec = 4'b1111;
    tick(12);
    chk("R6", dR[0], 1'b1, "digital held one cycle before settle end");
    tick(1);
    chk("R6", dR[0], 1'b0, "digital released after settle");
    chk("R9", rdy[0], 1'b1, "ready after settle");
    chk("R6", rdy[1], 1'b1, "nodet ready after settle");

    // R7: lane drop while ready
    lockVec = 4'b1011;
    tick(2);
    chk("R7", rdy[0], 1'b1, "ready before sync delay");
    tick(1);
    chk("R7", rdy[0], 1'b0, "ready dropped on lane loss");
    chk("R7", aR[0] & dR[0], 1'b1, "resets reasserted on lane loss");

    // recover
    lockVec = '0;
    tick(22);
    lockVec = '1;
    tick(16);
    chk("R9", rdy[0], 1'b1, "ready after recovery");
    chk("R5", rdy[1], 1'b1, "nodet ready after recovery");

    // R7 / R5: signal detect loss
    sigDet = 1'b0;
    tick(2);
    chk("R7", rdy[0], 1'b1, "ready before sigdet sync");
    tick(1);
    chk("R7", rdy[0], 1'b0, "ready dropped on sigdet loss");
    chk("R5", rdy[1], 1'b1, "nodet ignores sigdet loss");
    tick(4);
    chk("R5", rdy[1], 1'b1, "nodet still ready");

    // R2 in ready
    sigDet = 1'b1;
    startReq = 1'b1; tick(1); startReq = 1'b0;
    chk("R2", rdy[1], 1'b0, "restart from ready drops ready");
    chk("R2", aR[1] & dR[1], 1'b1, "restart from ready asserts resets");
    tick(5);
    finishRun();
  end

endmodule